// File: doc/BRIEF.md
# Masked Vector Integer Multiply-Add Unit

This block is a SIMD integer datapath that processes 512-bit vectors split into 16 lanes of 32 bits each. For every lane it multiplies operands A and B, keeps the low 32 bits of the product, and combines it with operand C. A 2-bit opcode selects one of four fused forms. One of those forms replaces C with the constant one.

A 16-bit predicate mask selects the lanes that take the new value. A disabled lane returns its C operand unchanged, so C doubles as the old destination value. All arithmetic wraps modulo 2^32, and no overflow indication is produced.

The datapath has two register stages: multiply, then combine and select. The input and output each use a valid/ready handshake. When the output is not stalled, the unit accepts one operation per clock.

Top module: `vmad_unit`

## Requirements
- R1: Opcode 2'b00 yields, in each enabled lane, the low 32 bits of A*B+C.
- R2: Opcode 2'b01 yields, in each enabled lane, the low 32 bits of A*B-C.
- R3: Opcode 2'b10 yields, in each enabled lane, the low 32 bits of C-A*B.
- R4: Opcode 2'b11 yields, in each enabled lane, the low 32 bits of 1-A*B. Operand C has no effect on enabled lanes.
- R5: A lane whose mask bit is 0 outputs its C operand unchanged, whatever the opcode.
- R6: The handshake on in_valid_i/in_ready_o takes effect on a clock edge. With out_ready_i high, the result is presented with out_valid_o high after the next rising edge, two cycles after the input was presented.
- R7: While out_valid_o is high and out_ready_i is low, in_ready_o is low, and out_valid_o and result_o hold their values.
- R8: While reset is asserted and straight after it, out_valid_o is 0 and in_ready_o is 1.
- R9: Lane i occupies bits [32i+31:32i] of every vector port and is gated by mask bit i. Lanes do not affect one another.
- R10: Operations presented on consecutive cycles without a stall come out on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| op_i | input | 2 | Fused operation select |
| mask_i | input | 16 | Per-lane write enable |
| src_a_i | input | 512 | Multiplicand vector |
| src_b_i | input | 512 | Multiplier vector |
| src_c_i | input | 512 | Addend / old destination vector |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Downstream takes result |
| result_o | output | 512 | Result vector |

## Verification
On every cycle, the assertions check the handshake timing: blocked input and frozen output under back-pressure, and the advance of an accepted operation through both stages. They also check that every lane disabled in the first stage emits the C value it captured. The arithmetic of the four opcodes, with wrap-around on corner values, can only be shown by the bench's sweeps. The same holds for the independence of lanes, in-order back-to-back flow, and release from a stall.

// File: rtl/vmad_pkg.sv
package vmad_pkg;
  typedef enum logic [1:0] {
    OP_MADD  = 2'b00,
    OP_MSUB  = 2'b01,
    OP_NMADD = 2'b10,
    OP_ONEMS = 2'b11
  } vmad_op_e;

  function automatic logic [31:0] combine32(vmad_op_e op, logic [31:0] p, logic [31:0] c);
    case (op)
      OP_MADD:  combine32 = p + c;
      OP_MSUB:  combine32 = p - c;
      OP_NMADD: combine32 = c - p;
      default:  combine32 = 32'd1 - p;
    endcase
  endfunction
endpackage

// File: rtl/vmad_ctrl.sv
module vmad_ctrl
  import vmad_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     in_valid_i,
  input  logic     out_ready_i,
  input  vmad_op_e op_i,
  output logic     adv_o,
  output logic     s1_valid_o,
  output vmad_op_e s1_op_o,
  output logic     out_valid_o
);
  logic     s1_valid_q, s2_valid_q;
  vmad_op_e s1_op_q;

  // whole pipe advances unless the output is held
  assign adv_o = !s2_valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s1_op_q    <= OP_MADD;
    end else if (adv_o) begin
      s1_valid_q <= in_valid_i;
      s2_valid_q <= s1_valid_q;
      s1_op_q    <= op_i;
    end
  end

  assign s1_valid_o  = s1_valid_q;
  assign s1_op_o     = s1_op_q;
  assign out_valid_o = s2_valid_q;
endmodule

// File: rtl/vmad_lane.sv
module vmad_lane
  import vmad_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  vmad_op_e     s1_op_i,
  output logic         s1_en_o,
  output logic [W-1:0] s1_c_o,
  output logic [W-1:0] res_o
);
  logic [W-1:0] prod_q, c_q, res_q, res_d;
  logic         en_q;

  always_comb begin
    if (!en_q) res_d = c_q;
    else       res_d = W'(combine32(s1_op_i, 32'(prod_q), 32'(c_q)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      c_q    <= '0;
      en_q   <= 1'b0;
      res_q  <= '0;
    end else if (adv_i) begin
      prod_q <= a_i * b_i;  // low W bits only
      c_q    <= c_i;
      en_q   <= en_i;
      res_q  <= res_d;
    end
  end

  assign s1_en_o = en_q;
  assign s1_c_o  = c_q;
  assign res_o   = res_q;
endmodule

// File: rtl/vmad_unit.sv
module vmad_unit
  import vmad_pkg::*;
#(
  parameter int LANES = 16,
  parameter int W     = 32,
  localparam int VW   = LANES * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       op_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [VW-1:0]    src_a_i,
  input  logic [VW-1:0]    src_b_i,
  input  logic [VW-1:0]    src_c_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VW-1:0]    result_o
);
  logic             adv;
  logic             s1_valid;
  vmad_op_e         s1_op;
  logic [LANES-1:0] s1_mask;
  logic [VW-1:0]    s1_c;

  vmad_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .op_i       (vmad_op_e'(op_i)),
    .adv_o      (adv),
    .s1_valid_o (s1_valid),
    .s1_op_o    (s1_op),
    .out_valid_o(out_valid_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vmad_lane #(.W(W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .en_i   (mask_i[l]),
      .a_i    (src_a_i[l*W +: W]),
      .b_i    (src_b_i[l*W +: W]),
      .c_i    (src_c_i[l*W +: W]),
      .s1_op_i(s1_op),
      .s1_en_o(s1_mask[l]),
      .s1_c_o (s1_c[l*W +: W]),
      .res_o  (result_o[l*W +: W])
    );
  end

  assign in_ready_o = adv;
endmodule

// File: rtl/vmad_checker.sv
module vmad_checker #(
  parameter int LANES = 16,
  parameter int W     = 32,
  localparam int VW   = LANES * W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [VW-1:0]    result_o,
  input logic             s1_valid,
  input logic [LANES-1:0] s1_mask,
  input logic [VW-1:0]    s1_c
);
  a_r7_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));

  a_r6_enter_stage1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> s1_valid);

  a_r6_reach_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && in_ready_o) |=> out_valid_o);

  a_r8_reset_idle: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!out_valid_o && in_ready_o));

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    a_r5_masked_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_ready_o && s1_valid && !s1_mask[l]) |=>
        (result_o[l*W +: W] == $past(s1_c[l*W +: W])));
  end
endmodule

bind vmad_unit vmad_checker #(.LANES(LANES), .W(W)) u_vmad_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .result_o   (result_o),
  .s1_valid   (s1_valid),
  .s1_mask    (s1_mask),
  .s1_c       (s1_c)
);

// File: tb/vmad_unit_bench.sv
module vmad_unit_bench;
  localparam int LANES = 16;
  localparam int W     = 32;
  localparam int VW    = LANES * W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       op = 2'b00;
  logic [LANES-1:0] mask = '0;
  logic [VW-1:0]    va = '0, vb = '0, vc = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [VW-1:0]    result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vmad_unit u_vmad_unit (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .mask_i(mask), .src_a_i(va), .src_b_i(vb), .src_c_i(vc),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result)
  );

  function automatic logic [31:0] corner(int k);
    case (k % 6)
      0: corner = 32'h0000_0000;
      1: corner = 32'h0000_0001;
      2: corner = 32'hFFFF_FFFF;
      3: corner = 32'h8000_0000;
      4: corner = 32'h7FFF_FFFF;
      default: corner = 32'h0001_0003;
    endcase
  endfunction

  function automatic logic [31:0] lane_exp(logic [1:0] o, logic m, logic [31:0] a,
                                           logic [31:0] b, logic [31:0] c);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    if (!m) return c;
    case (o)
      2'b00:   return full[31:0] + c;
      2'b01:   return full[31:0] - c;
      2'b10:   return c - full[31:0];
      default: return 32'd1 - full[31:0];
    endcase
  endfunction

  function automatic logic [VW-1:0] vec_exp(logic [1:0] o, logic [LANES-1:0] m,
      logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*W +: W] = lane_exp(o, m[l], a[l*W +: W], b[l*W +: W], c[l*W +: W]);
    return r;
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic make_vec(int p, output logic [VW-1:0] a, output logic [VW-1:0] b,
                          output logic [VW-1:0] c);
    for (int l = 0; l < LANES; l++) begin
      if (p < 3) begin
        a[l*W +: W] = corner(l + p);
        b[l*W +: W] = corner(l * 5 + p + 1);
        c[l*W +: W] = corner(l * 7 + p + 2);
      end else begin
        a[l*W +: W] = 32'(p * 32'h0100_0193 + l * 32'h9E37_79B9);
        b[l*W +: W] = 32'(p * 32'h85EB_CA6B ^ (l * 32'h0000_C2B3 + 32'h1234_5677));
        c[l*W +: W] = 32'(p * 32'h27D4_EB2F + l * 32'h1656_67B1);
      end
    end
  endtask

  function automatic string req_of(logic [1:0] o, logic [LANES-1:0] m);
    if (m == '0) return "R5";
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] masks [6];
    logic [VW-1:0] ta, tb, tc, e0, e1, e2;
    logic [VW-1:0] sa [3], sb [3], sc [3];
    masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hAAAA;
    masks[3] = 16'h5555; masks[4] = 16'h0001; masks[5] = 16'h8000;

    repeat (3) @(negedge clk);
    // R8: reset state
    check_bit("R8 out_valid in reset", out_valid, 1'b0);
    check_bit("R8 in_ready in reset", in_ready, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    check_bit("R8 out_valid after reset", out_valid, 1'b0);

    // R1-R5, R6, R9: sweep opcode x mask x operand pattern
    for (int o = 0; o < 4; o++)
      for (int mi = 0; mi < 6; mi++)
        for (int p = 0; p < 8; p++) begin
          make_vec(p, ta, tb, tc);
          op = 2'(o); mask = masks[mi]; va = ta; vb = tb; vc = tc;
          in_valid = 1'b1;
          @(negedge clk);
          in_valid = 1'b0;
          va = ~ta; vc = ~tc;  // later inputs must not disturb the result
          @(negedge clk);
          check_bit("R6 out_valid", out_valid, 1'b1);
          // R9: full-vector compare covers lane placement and mask bit i
          check(req_of(2'(o), masks[mi]), result, vec_exp(2'(o), masks[mi], ta, tb, tc));
          @(negedge clk);
          check_bit("R6 out_valid drops", out_valid, 1'b0);
        end

    // R4: C has no effect on enabled lanes
    make_vec(5, ta, tb, tc);
    op = 2'b11; mask = '1; va = ta; vb = tb; vc = '1; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check("R4 c ignored", result, vec_exp(2'b11, '1, ta, tb, '0));
    @(negedge clk);

    // R10: back-to-back
    for (int k = 0; k < 3; k++) make_vec(10 + k, sa[k], sb[k], sc[k]);
    e0 = vec_exp(2'b00, 16'hF0F0, sa[0], sb[0], sc[0]);
    e1 = vec_exp(2'b01, 16'h0FFF, sa[1], sb[1], sc[1]);
    e2 = vec_exp(2'b10, 16'hFFFF, sa[2], sb[2], sc[2]);
    op = 2'b00; mask = 16'hF0F0; va = sa[0]; vb = sb[0]; vc = sc[0]; in_valid = 1'b1;
    @(negedge clk);
    op = 2'b01; mask = 16'h0FFF; va = sa[1]; vb = sb[1]; vc = sc[1];
    @(negedge clk);
    check("R10 first", result, e0);
    op = 2'b10; mask = 16'hFFFF; va = sa[2]; vb = sb[2]; vc = sc[2];
    @(negedge clk);
    check("R10 second", result, e1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 third", result, e2);
    @(negedge clk);

    // R7: stall
    out_ready = 1'b0;
    op = 2'b00; mask = '1; va = sa[0]; vb = sb[0]; vc = sc[0]; in_valid = 1'b1;
    @(negedge clk);
    op = 2'b10; va = sa[1]; vb = sb[1]; vc = sc[1];
    @(negedge clk);
    in_valid = 1'b0;
    e0 = vec_exp(2'b00, '1, sa[0], sb[0], sc[0]);
    e1 = vec_exp(2'b10, '1, sa[1], sb[1], sc[1]);
    repeat (3) begin
      check_bit("R7 ready low in stall", in_ready, 1'b0);
      check_bit("R7 valid held", out_valid, 1'b1);
      check("R7 result held", result, e0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 second after release", result, e1);
    check_bit("R7 valid after release", out_valid, 1'b1);
    @(negedge clk);
    check_bit("R7 drained", out_valid, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule